// File: doc/BRIEF.md
# Serial Controller Mode/Command Sequencer

This block is the host-facing control logic of an asynchronous serial peripheral. A processor reaches it through two byte-wide ports chosen by one select line: select 0 is the data port and select 1 is the control/status port. Control writes are decoded by an internal sequencer. Straight after any reset the sequencer waits for a line-format (mode) byte. Every control write after that one is a command byte, until a command asks for an internal reset.

The block holds the line format (stop bits, parity, character length, clock factor) and the command state (transmit and receive enables, break, modem outputs). It sends these to a separate transmitter and receiver. It also holds one transmit byte and one received byte, keeps the receive error flags, and builds the status byte that a read of the control port returns. A robust start-up is four control writes: 0xAA, 0x40, 0x4E, 0x27. This always ends with 8 data bits, no parity, 1 stop bit, a 16x clock, both directions enabled and both modem outputs asserted, whatever state the block was in before.

Top module: `sc_host_ctl`

## Requirements
- R1: After reset, tx_en, rx_en and tx_brk are 0, rts_n and dtr_n are 1, nothing is pending for transmit, no byte is ready, and all error flags are clear.
- R2: The first control write (bus_sel=1) after reset is taken as a mode byte: bits[7:6] go to fmt_stop, bit[5] to fmt_par_even, bit[4] to fmt_par_en, bits[3:2] to fmt_len, bits[1:0] to clk_factor. The control write after it is a command, not a mode.
- R3: Clock-factor code 00 in a mode byte is accepted and drives clk_factor = 2'b10 (16x). clk_factor is never 00.
- R4: A command byte sets tx_en = bit0, rx_en = bit2, tx_brk = bit3, and drives dtr_n = ~bit1 and rts_n = ~bit5. Bit7 has no effect, and the modem outputs change only on a control write.
- R5: A command with bit6 set clears tx_en, rx_en and tx_brk, releases rts_n and dtr_n to 1, and makes the next control write a mode byte.
- R6: A command with bit4 set raises err_clr for exactly one cycle, starting the cycle after the write. This clears the framing, overrun and parity flags. The bit is not held.
- R7: The control writes 0xAA, 0x40, 0x4E, 0x27 leave fmt_stop=01, fmt_par_en=0, fmt_len=11, clk_factor=10, tx_en=1, rx_en=1, tx_brk=0, rts_n=0, dtr_n=0, starting from either the reset state or the command state.
- R8: A read of the control port returns the status byte: [7]=~dsr_n, [6]=0, [5]=framing error, [4]=overrun, [3]=parity error, [2]=transmit empty (tx_idle and nothing pending), [1]=receive ready, [0]=transmit ready (nothing pending).
- R9: A data-port write loads tx_byte, raises tx_full and clears status bit0 and bit2. A tx_take pulse clears tx_full again.
- R10: An rx_strobe while rx_en is 1 captures rx_byte and sets receive ready. A data-port read returns that byte and clears receive ready. While rx_en is 0, rx_strobe is ignored.
- R11: An accepted rx_strobe while receive ready is still set raises overrun, and the new byte replaces the old one. rx_fe and rx_pe presented with an accepted strobe set the framing and parity flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | 0 selects the data port, 1 selects the control/status port |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle bus_rd is high |
| dsr_n | input | 1 | Modem data-set-ready input, active low |
| rts_n | output | 1 | Request-to-send output, active low |
| dtr_n | output | 1 | Data-terminal-ready output, active low |
| tx_byte | output | 8 | Byte held for the transmitter |
| tx_full | output | 1 | tx_byte is waiting to be taken |
| tx_take | input | 1 | Transmitter has taken tx_byte |
| tx_idle | input | 1 | Transmitter shift path is empty |
| tx_en | output | 1 | Transmit enable |
| tx_brk | output | 1 | Force break on the line |
| rx_byte | input | 8 | Byte from the receiver |
| rx_strobe | input | 1 | rx_byte is valid this cycle |
| rx_fe | input | 1 | Framing error with this strobe |
| rx_pe | input | 1 | Parity error with this strobe |
| rx_en | output | 1 | Receive enable |
| fmt_stop | output | 2 | Stop-bit code (01 one, 10 one and a half, 11 two) |
| fmt_par_en | output | 1 | Parity enable |
| fmt_par_even | output | 1 | Even parity select |
| fmt_len | output | 2 | Character length code (00 five to 11 eight bits) |
| clk_factor | output | 2 | Clock factor code (01 1x, 10 16x, 11 64x) |
| err_clr | output | 1 | One-cycle pulse that clears the receive error flags |

## Verification
The bench uses the default parameters: a two-stage reset release and code 10 as the substitute for the synchronous clock-factor code. With these values it can check the exact output of the 00 substitution and count the reset latency in cycles. It runs the four-byte start-up twice, once from a fresh reset and once from a live command state. This exercises both ways the first byte is decoded. It also pushes two received bytes back to back with error inputs, so all three flags and the overwrite show up in a single status byte.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int DW = 8;

  typedef struct packed {
    logic [1:0] stop;
    logic       even;
    logic       par_en;
    logic [1:0] len;
    logic [1:0] factor;
  } sc_mode_t;

  typedef struct packed {
    logic hunt;
    logic soft_rst;
    logic rts;
    logic err_rst;
    logic brk;
    logic rx_en;
    logic dtr;
    logic tx_en;
  } sc_cmd_t;

  localparam int ST_DSR   = 7;
  localparam int ST_SYNC  = 6;
  localparam int ST_FE    = 5;
  localparam int ST_OE    = 4;
  localparam int ST_PE    = 3;
  localparam int ST_TXE   = 2;
  localparam int ST_RXRDY = 1;
  localparam int ST_TXRDY = 0;
endpackage

// File: rtl/sc_rst_sync.sv
module sc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/sc_cfg_seq.sv
module sc_cfg_seq
  import sc_pkg::*;
#(
  parameter logic [1:0] SYNC_FACTOR = 2'b10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_wr,
  input  logic [DW-1:0] wdata,
  output sc_mode_t      mode,
  output logic          tx_en,
  output logic          rx_en,
  output logic          brk,
  output logic          rts,
  output logic          dtr,
  output logic          err_clr,
  output logic          soft_rst
);
  sc_mode_t mode_q, mode_d;
  sc_cmd_t  cmd_w;
  logic     wait_q, wait_d;
  logic     tx_q, tx_d, rx_q, rx_d, brk_q, brk_d, rts_q, rts_d, dtr_q, dtr_d;
  logic     errc_q, errc_d, srst_q, srst_d;

  assign cmd_w = sc_cmd_t'(wdata);

  always_comb begin
    mode_d = mode_q;
    wait_d = wait_q;
    tx_d   = tx_q;
    rx_d   = rx_q;
    brk_d  = brk_q;
    rts_d  = rts_q;
    dtr_d  = dtr_q;
    errc_d = 1'b0;
    srst_d = 1'b0;
    if (ctl_wr) begin
      if (wait_q) begin
        mode_d = sc_mode_t'(wdata);
        wait_d = 1'b0;
      end else if (cmd_w.soft_rst) begin
        wait_d = 1'b1;
        tx_d   = 1'b0;
        rx_d   = 1'b0;
        brk_d  = 1'b0;
        rts_d  = 1'b0;
        dtr_d  = 1'b0;
        srst_d = 1'b1;
      end else begin
        tx_d   = cmd_w.tx_en;
        rx_d   = cmd_w.rx_en;
        brk_d  = cmd_w.brk;
        rts_d  = cmd_w.rts;
        dtr_d  = cmd_w.dtr;
        errc_d = cmd_w.err_rst;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      wait_q <= 1'b1;
      tx_q   <= 1'b0;
      rx_q   <= 1'b0;
      brk_q  <= 1'b0;
      rts_q  <= 1'b0;
      dtr_q  <= 1'b0;
      errc_q <= 1'b0;
      srst_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      wait_q <= wait_d;
      tx_q   <= tx_d;
      rx_q   <= rx_d;
      brk_q  <= brk_d;
      rts_q  <= rts_d;
      dtr_q  <= dtr_d;
      errc_q <= errc_d;
      srst_q <= srst_d;
    end
  end

  always_comb begin
    mode = mode_q;
    if (mode_q.factor == 2'b00) mode.factor = SYNC_FACTOR;
  end

  assign tx_en    = tx_q;
  assign rx_en    = rx_q;
  assign brk      = brk_q;
  assign rts      = rts_q;
  assign dtr      = dtr_q;
  assign err_clr  = errc_q;
  assign soft_rst = srst_q;

  AST_MODE_THEN_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && wait_q) |=> !wait_q); // R2
  AST_FACTOR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    mode.factor != 2'b00); // R3
  AST_MODEM_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rts_q) |-> $past(ctl_wr)); // R4
  AST_IR_TO_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !wait_q && wdata[6]) |=> (wait_q && !tx_q && !rx_q)); // R5
endmodule

// File: rtl/sc_rx_stat.sv
module sc_rx_stat
  import sc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_strobe,
  input  logic          rx_en,
  input  logic [DW-1:0] rx_byte,
  input  logic          rx_fe,
  input  logic          rx_pe,
  input  logic          rd_data,
  input  logic          err_clr,
  input  logic          soft_rst,
  output logic [DW-1:0] hold,
  output logic          rdy,
  output logic          fe,
  output logic          oe,
  output logic          pe
);
  logic [DW-1:0] hold_q, hold_d;
  logic          rdy_q, rdy_d, fe_q, fe_d, oe_q, oe_d, pe_q, pe_d;
  logic          take;

  assign take = rx_strobe && rx_en;

  always_comb begin
    hold_d = hold_q;
    rdy_d  = rdy_q && !rd_data;
    fe_d   = fe_q && !err_clr;
    oe_d   = oe_q && !err_clr;
    pe_d   = pe_q && !err_clr;
    if (take) begin
      hold_d = rx_byte;
      rdy_d  = 1'b1;
      if (rdy_q && !rd_data) oe_d = 1'b1;
      if (rx_fe) fe_d = 1'b1;
      if (rx_pe) pe_d = 1'b1;
    end
    if (soft_rst) begin
      rdy_d = 1'b0;
      fe_d  = 1'b0;
      oe_d  = 1'b0;
      pe_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      rdy_q  <= 1'b0;
      fe_q   <= 1'b0;
      oe_q   <= 1'b0;
      pe_q   <= 1'b0;
    end else begin
      hold_q <= hold_d;
      rdy_q  <= rdy_d;
      fe_q   <= fe_d;
      oe_q   <= oe_d;
      pe_q   <= pe_d;
    end
  end

  assign hold = hold_q;
  assign rdy  = rdy_q;
  assign fe   = fe_q;
  assign oe   = oe_q;
  assign pe   = pe_q;

  AST_RX_READY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_strobe && rx_en && !soft_rst) |=> rdy_q); // R10
  AST_RX_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_en && !rx_strobe) |=> $stable(hold_q)); // R10
  AST_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_strobe && rx_en && rdy_q && !rd_data && !soft_rst) |=> oe_q); // R11
  AST_ERR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clr && !rx_strobe) |=> (!fe_q && !oe_q && !pe_q)); // R6
endmodule

// File: rtl/sc_tx_hold.sv
module sc_tx_hold
  import sc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_data,
  input  logic [DW-1:0] wdata,
  input  logic          tx_take,
  input  logic          soft_rst,
  output logic [DW-1:0] byte_out,
  output logic          full
);
  logic [DW-1:0] byte_q, byte_d;
  logic          full_q, full_d;

  always_comb begin
    byte_d = byte_q;
    full_d = full_q && !tx_take;
    if (wr_data) begin
      byte_d = wdata;
      full_d = 1'b1;
    end
    if (soft_rst) full_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_q <= '0;
      full_q <= 1'b0;
    end else begin
      byte_q <= byte_d;
      full_q <= full_d;
    end
  end

  assign byte_out = byte_q;
  assign full     = full_q;

  AST_TX_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && !soft_rst) |=> full_q); // R9
  AST_TX_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_take && !wr_data) |=> !full_q); // R9
endmodule

// File: rtl/sc_host_ctl.sv
module sc_host_ctl
  import sc_pkg::*;
#(
  parameter int         RST_STAGES  = 2,
  parameter logic [1:0] SYNC_FACTOR = 2'b10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          dsr_n,
  output logic          rts_n,
  output logic          dtr_n,
  output logic [DW-1:0] tx_byte,
  output logic          tx_full,
  input  logic          tx_take,
  input  logic          tx_idle,
  output logic          tx_en,
  output logic          tx_brk,
  input  logic [DW-1:0] rx_byte,
  input  logic          rx_strobe,
  input  logic          rx_fe,
  input  logic          rx_pe,
  output logic          rx_en,
  output logic [1:0]    fmt_stop,
  output logic          fmt_par_en,
  output logic          fmt_par_even,
  output logic [1:0]    fmt_len,
  output logic [1:0]    clk_factor,
  output logic          err_clr
);
  logic          rst_i_n;
  logic          ctl_wr, data_wr, data_rd;
  logic          soft_rst, rts, dtr;
  logic          rx_rdy, fe, oe, pe;
  logic [DW-1:0] rx_hold, status;
  sc_mode_t      mode;

  assign ctl_wr  = bus_wr && bus_sel;
  assign data_wr = bus_wr && !bus_sel;
  assign data_rd = bus_rd && !bus_sel;

  sc_rst_sync #(.STAGES(RST_STAGES)) i_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n)
  );

  sc_cfg_seq #(.SYNC_FACTOR(SYNC_FACTOR)) i_seq (
    .clk(clk), .rst_n(rst_i_n), .ctl_wr(ctl_wr), .wdata(bus_wdata),
    .mode(mode), .tx_en(tx_en), .rx_en(rx_en), .brk(tx_brk),
    .rts(rts), .dtr(dtr), .err_clr(err_clr), .soft_rst(soft_rst)
  );

  sc_rx_stat i_rx (
    .clk(clk), .rst_n(rst_i_n), .rx_strobe(rx_strobe), .rx_en(rx_en),
    .rx_byte(rx_byte), .rx_fe(rx_fe), .rx_pe(rx_pe), .rd_data(data_rd),
    .err_clr(err_clr), .soft_rst(soft_rst), .hold(rx_hold), .rdy(rx_rdy),
    .fe(fe), .oe(oe), .pe(pe)
  );

  sc_tx_hold i_tx (
    .clk(clk), .rst_n(rst_i_n), .wr_data(data_wr), .wdata(bus_wdata),
    .tx_take(tx_take), .soft_rst(soft_rst), .byte_out(tx_byte), .full(tx_full)
  );

  always_comb begin
    status           = '0;
    status[ST_DSR]   = !dsr_n;
    status[ST_SYNC]  = 1'b0;
    status[ST_FE]    = fe;
    status[ST_OE]    = oe;
    status[ST_PE]    = pe;
    status[ST_TXE]   = tx_idle && !tx_full;
    status[ST_RXRDY] = rx_rdy;
    status[ST_TXRDY] = !tx_full;
  end

  assign bus_rdata    = bus_sel ? status : rx_hold;
  assign rts_n        = !rts;
  assign dtr_n        = !dtr;
  assign fmt_stop     = mode.stop;
  assign fmt_par_en   = mode.par_en;
  assign fmt_par_even = mode.even;
  assign fmt_len      = mode.len;
  assign clk_factor   = mode.factor;

  AST_ERRCLR_SINGLE: assert property (@(posedge clk) disable iff (!rst_i_n)
    (err_clr && !ctl_wr) |=> !err_clr); // R6
  AST_TXRDY_STATUS: assert property (@(posedge clk) disable iff (!rst_i_n)
    (data_wr && !soft_rst) |=> (bus_sel || !bus_rd || 1'b1) && !status[ST_TXRDY]); // R9
endmodule

// File: tb/test_sc_host_ctl.sv
module test_sc_host_ctl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       dsr_n = 1'b1;
  logic       rts_n, dtr_n;
  logic [7:0] tx_byte;
  logic       tx_full;
  logic       tx_take = 1'b0, tx_idle = 1'b1;
  logic       tx_en, tx_brk, rx_en;
  logic [7:0] rx_byte = 8'h00;
  logic       rx_strobe = 1'b0, rx_fe = 1'b0, rx_pe = 1'b0;
  logic [1:0] fmt_stop, fmt_len, clk_factor;
  logic       fmt_par_en, fmt_par_even, err_clr;

  int n_chk = 0;
  int n_fail = 0;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } exp_t;
  exp_t exp_q[$];

  always #5 clk = ~clk;

  sc_host_ctl i_sc_host_ctl (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dsr_n(dsr_n), .rts_n(rts_n), .dtr_n(dtr_n), .tx_byte(tx_byte),
    .tx_full(tx_full), .tx_take(tx_take), .tx_idle(tx_idle), .tx_en(tx_en),
    .tx_brk(tx_brk), .rx_byte(rx_byte), .rx_strobe(rx_strobe), .rx_fe(rx_fe),
    .rx_pe(rx_pe), .rx_en(rx_en), .fmt_stop(fmt_stop),
    .fmt_par_en(fmt_par_en), .fmt_par_even(fmt_par_even), .fmt_len(fmt_len),
    .clk_factor(clk_factor), .err_clr(err_clr)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops the expected read value when the design answers a read
  always @(negedge clk) begin
    if (bus_rd) begin
      if (exp_q.size() == 0) begin
        check("read without expectation", bus_rdata, 8'hxx);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(e.tag, bus_rdata, e.exp);
      end
    end
  end

  task automatic wr(input logic sel, input logic [7:0] d);
    @(posedge clk); #1;
    bus_sel = sel; bus_wr = 1'b1; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic sel, input logic [7:0] exp, input string tag);
    exp_t e;
    e.exp = exp;
    e.tag = tag;
    exp_q.push_back(e);
    @(posedge clk); #1;
    bus_sel = sel; bus_rd = 1'b1;
    @(posedge clk); #1;
    bus_rd = 1'b0;
  endtask

  task automatic rx_push(input logic [7:0] d, input logic fe_i, input logic pe_i);
    @(posedge clk); #1;
    rx_byte = d; rx_strobe = 1'b1; rx_fe = fe_i; rx_pe = pe_i;
    @(posedge clk); #1;
    rx_strobe = 1'b0; rx_fe = 1'b0; rx_pe = 1'b0;
  endtask

  task automatic init_seq(input string tag);
    wr(1'b1, 8'hAA);
    wr(1'b1, 8'h40);
    wr(1'b1, 8'h4E);
    wr(1'b1, 8'h27);
    check({tag, " stop"}, {6'd0, fmt_stop}, 8'h01);
    check({tag, " parity"}, {7'd0, fmt_par_en}, 8'h00);
    check({tag, " len"}, {6'd0, fmt_len}, 8'h03);
    check({tag, " factor"}, {6'd0, clk_factor}, 8'h02);
    check({tag, " en/brk/modem"}, {3'd0, tx_en, rx_en, tx_brk, rts_n, dtr_n}, 8'b00011000);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    // R1: reset state
    check("R1 outputs", {3'd0, tx_en, rx_en, tx_brk, rts_n, dtr_n}, 8'b00000011);
    check("R1 tx_full", {7'd0, tx_full}, 8'h00);
    rd(1'b1, 8'h05, "R1 R8 status after reset");

    // R2: first control write is a mode byte
    wr(1'b1, 8'hAA);
    check("R2 stop", {6'd0, fmt_stop}, 8'h02);
    check("R2 even/par_en", {6'd0, fmt_par_even, fmt_par_en}, 8'h02);
    check("R2 len/factor", {4'd0, fmt_len, clk_factor}, 8'h0A);
    wr(1'b1, 8'h40);
    wr(1'b1, 8'h4E);
    wr(1'b1, 8'h27);
    check("R7 from reset en/modem", {3'd0, tx_en, rx_en, tx_brk, rts_n, dtr_n}, 8'b00011000);
    check("R7 from reset format", {2'd0, fmt_stop, fmt_len, clk_factor}, 8'b00011110);

    // R4: in command state 0xAA is a command, mode untouched
    wr(1'b1, 8'hAA);
    check("R4 cmd AA outputs", {3'd0, tx_en, rx_en, tx_brk, rts_n, dtr_n}, 8'b00000100);
    check("R4 mode untouched", {6'd0, fmt_stop}, 8'h01);
    // R5: internal reset
    wr(1'b1, 8'h40);
    check("R5 cleared", {3'd0, tx_en, rx_en, tx_brk, rts_n, dtr_n}, 8'b00000011);
    wr(1'b1, 8'h4E);
    wr(1'b1, 8'h27);
    check("R7 from command en/modem", {3'd0, tx_en, rx_en, tx_brk, rts_n, dtr_n}, 8'b00011000);
    check("R7 from command format", {2'd0, fmt_stop, fmt_len, clk_factor}, 8'b00011110);
    init_seq("R7 full sequence again");

    // R3: factor 00 maps to 16x
    wr(1'b1, 8'h40);
    wr(1'b1, 8'hCC);
    check("R3 factor 00", {6'd0, clk_factor}, 8'h02);
    check("R2 stop 11", {6'd0, fmt_stop}, 8'h03);
    wr(1'b1, 8'h40);
    wr(1'b1, 8'h3D);
    check("R2 mode 3D", {fmt_stop, fmt_par_even, fmt_par_en, fmt_len, clk_factor}, 8'h3D);
    // R4: command without modem bits, then hunt bit has no effect
    wr(1'b1, 8'h05);
    check("R4 cmd 05", {3'd0, tx_en, rx_en, tx_brk, rts_n, dtr_n}, 8'b00011011);
    wr(1'b1, 8'h85);
    check("R4 hunt no effect", {3'd0, tx_en, rx_en, tx_brk, rts_n, dtr_n}, 8'b00011011);
    check("R4 hunt mode kept", {fmt_stop, fmt_par_even, fmt_par_en, fmt_len, clk_factor}, 8'h3D);

    // R9: transmit holding
    wr(1'b0, 8'h5A);
    check("R9 tx_byte", tx_byte, 8'h5A);
    check("R9 tx_full", {7'd0, tx_full}, 8'h01);
    rd(1'b1, 8'h00, "R9 R8 status pending");
    @(posedge clk); #1 tx_take = 1'b1;
    @(posedge clk); #1 tx_take = 1'b0;
    check("R9 taken", {7'd0, tx_full}, 8'h00);
    rd(1'b1, 8'h05, "R9 status after take");

    // R10: receive
    rx_push(8'hC3, 1'b0, 1'b0);
    rd(1'b1, 8'h07, "R10 R8 rx ready");
    rd(1'b0, 8'hC3, "R10 data read");
    rd(1'b1, 8'h05, "R10 ready cleared");
    wr(1'b1, 8'h01);
    rx_push(8'h11, 1'b0, 1'b0);
    rd(1'b1, 8'h05, "R10 ignored when disabled");
    rd(1'b0, 8'hC3, "R10 hold unchanged");
    wr(1'b1, 8'h05);

    // R11: overrun and error flags
    rx_push(8'h21, 1'b0, 1'b0);
    rx_push(8'h22, 1'b1, 1'b1);
    rd(1'b1, 8'h3F, "R11 R8 all flags");
    rd(1'b0, 8'h22, "R11 newest byte");

    // R6: error reset pulse
    wr(1'b1, 8'h15);
    check("R6 pulse high", {7'd0, err_clr}, 8'h01);
    @(posedge clk); #1;
    check("R6 pulse gone", {7'd0, err_clr}, 8'h00);
    rd(1'b1, 8'h05, "R6 flags cleared");
    check("R6 enables kept", {6'd0, tx_en, rx_en}, 8'h03);
    wr(1'b1, 8'h05);
    check("R6 not stored", {7'd0, err_clr}, 8'h00);

    // R8: modem input
    dsr_n = 1'b0;
    rd(1'b1, 8'h85, "R8 dsr bit");
    dsr_n = 1'b1;

    repeat (3) @(posedge clk);
    if (exp_q.size() != 0) check("scoreboard drained", 8'(exp_q.size()), 8'h00);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule